// File: doc/BRIEF.md
# Write-Tracking Descriptor Permission Checker

This block sits beside a page-table walker and settles the permission outcome of one access against one 64-bit translation descriptor. The walker hands over a descriptor address and says whether the access is a read or a write. The block fetches the descriptor over a simple memory port and then does one of three things. It grants the access. It reports a fault. Or, when a write hits a page that is write-protected but marked as eligible for hardware dirty tracking, it clears the write-protect bit in memory and then grants the write. After such an update, a cleared write-protect bit tells software that the page is dirty, and a set bit tells it that the page is still clean.

The descriptor is rewritten with a locked read-modify-write. The block first reads the descriptor without the lock. If that read shows an upgrade case, it reads the descriptor again with the lock raised. It keeps the lock raised until the write-back is acknowledged. If the locked read no longer shows an upgrade case, the block drops the lock without writing and bases its answer on the fresh value. A global enable input can switch the hardware update off. When it is off, write-protected pages fault on writes.

Top module: `dsc_dirty_upd`

## Requirements
- R1: While reset is asserted and until the internal reset releases, `req_ready`, `rsp_valid`, `mem_req` and `mem_lock` are all low. Shortly after release, `req_ready` is high.
- R2: A write to a valid descriptor whose bit 7 is 1 (write-protected) and whose bit 51 is 1 (tracking allowed), with `upd_en` high, is granted with fault code 0. The descriptor in memory becomes its previous value with bit 7 cleared and every other bit kept.
- R3: A write to a valid descriptor whose bit 7 is 1 and whose bit 51 is 0 returns fault code 2 (permission) with the grant low. No memory write is issued.
- R4: A write to a valid descriptor whose bit 7 is 0 is granted with fault code 0, whatever bit 51 holds. No memory write is issued.
- R5: A read to a valid descriptor is granted with fault code 0, whatever bits 7 and 51 hold. No memory write is issued.
- R6: A descriptor whose bit 0 is 0 returns fault code 1 (translation) for reads and for writes. No memory write is issued.
- R7: Every memory write carries `mem_lock`. The lock rises with a locked re-read, stays high without a gap until the write-back is acknowledged, and is never raised on the first, plain read.
- R8: If the locked re-read no longer shows bit 0 = 1, bit 7 = 1 and bit 51 = 1, the block issues no write. It answers from the re-read value using the rules of R3 to R6.
- R9: When `upd_en` is low at acceptance, bit 51 is treated as 0. A write to a write-protected page then faults with code 2 and leaves memory unchanged.
- R10: Only one request is in flight. `req_ready` is high only when the block is idle. `rsp_valid` is a single-cycle pulse that rises in the cycle after the last memory acknowledge. A grant always carries fault code 0, and a fault never carries the grant. Memory request, address, write flag and lock stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_en | input | 1 | Global enable for the hardware dirty update, sampled at acceptance |
| req_valid | input | 1 | Walker request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Byte address of the descriptor |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 2 | 0 none, 1 translation, 2 permission |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | Memory access is a write |
| mem_lock | output | 1 | Locked access; no other agent may touch the word |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data (descriptor with bit 7 cleared) |
| mem_ack | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bench builds the block with a 12-bit address and the default 64-bit descriptor, with the tracking bit at 51, the write-protect bit at 7 and the valid bit at 0. Under these values, 8-byte descriptors index a sixteen-word memory model directly. That memory model can act as a second agent. It rewrites a descriptor just after the unlocked fetch, which makes the re-read paths of R8 reachable: the page became writable, the tracking bit was cleared, the valid bit was dropped, or other fields changed while the upgrade still holds. With the one-cycle acknowledge latency of that model, the three response latencies (plain, re-read only, full update) fall on fixed cycles that the reference model checks every clock.

// File: rtl/dsc_dirty_pkg.sv
package dsc_dirty_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOCK_RD,
    ST_WRBACK,
    ST_RESP
  } dsc_state_e;

  typedef enum logic [1:0] {
    VD_GRANT,
    VD_XLAT,
    VD_PERM,
    VD_MARK
  } dsc_verdict_e;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_XLAT = 2'd1;
  localparam logic [1:0] FLT_PERM = 2'd2;

endpackage

// File: rtl/dsc_dirty_rstsync.sv
module dsc_dirty_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dsc_dirty_decide.sv
module dsc_dirty_decide
  import dsc_dirty_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int VLD_BIT = 0,
  parameter int RO_BIT  = 7,
  parameter int MOD_BIT = 51
) (
  input  logic [DATA_W-1:0] desc,
  input  logic              is_write,
  input  logic              upd_en,
  output dsc_verdict_e      verdict,
  output logic [DATA_W-1:0] marked
);

  localparam logic [DATA_W-1:0] RO_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << RO_BIT;

  logic page_valid;
  logic page_ro;
  logic track_ok;

  assign page_valid = desc[VLD_BIT];
  assign page_ro    = desc[RO_BIT];
  assign track_ok   = desc[MOD_BIT] & upd_en;

  always_comb begin
    if (!page_valid)                verdict = VD_XLAT;
    else if (!is_write || !page_ro) verdict = VD_GRANT;
    else if (track_ok)              verdict = VD_MARK;
    else                            verdict = VD_PERM;
  end

  assign marked = desc & ~RO_MASK;

endmodule

// File: rtl/dsc_dirty_dp.sv
module dsc_dirty_dp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              upd_en,
  input  logic              desc_ld,
  input  logic [DATA_W-1:0] desc_in,
  input  logic              res_ld,
  input  logic              res_grant,
  input  logic [1:0]        res_fault,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic              en_q,
  output logic [DATA_W-1:0] desc_q,
  output logic              grant_q,
  output logic [1:0]        fault_q
);

  logic [ADDR_W-1:0] addr_d;
  logic              wr_d;
  logic              en_d;
  logic [DATA_W-1:0] desc_d;
  logic              grant_d;
  logic [1:0]        fault_d;

  always_comb begin
    addr_d  = addr_q;
    wr_d    = wr_q;
    en_d    = en_q;
    desc_d  = desc_q;
    grant_d = grant_q;
    fault_d = fault_q;
    if (accept) begin
      addr_d = req_addr;
      wr_d   = req_write;
      en_d   = upd_en;
    end
    if (desc_ld) desc_d = desc_in;
    if (res_ld) begin
      grant_d = res_grant;
      fault_d = res_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      en_q    <= 1'b0;
      desc_q  <= '0;
      grant_q <= 1'b0;
      fault_q <= 2'd0;
    end else begin
      addr_q  <= addr_d;
      wr_q    <= wr_d;
      en_q    <= en_d;
      desc_q  <= desc_d;
      grant_q <= grant_d;
      fault_q <= fault_d;
    end
  end

endmodule

// File: rtl/dsc_dirty_ctrl.sv
module dsc_dirty_ctrl
  import dsc_dirty_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         mem_ack,
  input  dsc_verdict_e verdict,
  output logic         req_ready,
  output logic         accept,
  output logic         rsp_valid,
  output logic         mem_req,
  output logic         mem_we,
  output logic         mem_lock,
  output logic         desc_ld,
  output logic         res_ld,
  output logic         res_grant,
  output logic [1:0]   res_fault
);

  dsc_state_e state_q;
  dsc_state_e state_d;

  assign req_ready = (state_q == ST_IDLE) && rst_n;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (state_q == ST_RESP);
  assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_LOCK_RD) || (state_q == ST_WRBACK);
  assign mem_we    = (state_q == ST_WRBACK);
  assign mem_lock  = (state_q == ST_LOCK_RD) || (state_q == ST_WRBACK);

  // result mapping: a completed write-back always grants
  always_comb begin
    if (state_q == ST_WRBACK) begin
      res_fault = FLT_NONE;
    end else begin
      case (verdict)
        VD_XLAT: res_fault = FLT_XLAT;
        VD_PERM: res_fault = FLT_PERM;
        default: res_fault = FLT_NONE;
      endcase
    end
    res_grant = (res_fault == FLT_NONE);
  end

  always_comb begin
    state_d = state_q;
    desc_ld = 1'b0;
    res_ld  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (verdict == VD_MARK) begin
            state_d = ST_LOCK_RD;
          end else begin
            res_ld  = 1'b1;
            state_d = ST_RESP;
          end
        end
      end
      ST_LOCK_RD: begin
        if (mem_ack) begin
          if (verdict == VD_MARK) begin
            desc_ld = 1'b1;
            state_d = ST_WRBACK;
          end else begin
            res_ld  = 1'b1;
            state_d = ST_RESP;
          end
        end
      end
      ST_WRBACK: begin
        if (mem_ack) begin
          res_ld  = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dsc_dirty_upd.sv
module dsc_dirty_upd
  import dsc_dirty_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int VLD_BIT     = 0,
  parameter int RO_BIT      = 7,
  parameter int MOD_BIT     = 51,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [1:0]        rsp_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              rst_q_n;
  logic              accept;
  logic              desc_ld;
  logic              res_ld;
  logic              res_grant;
  logic [1:0]        res_fault;
  logic              wr_q;
  logic              en_q;
  logic              grant_q;
  logic [1:0]        fault_q;
  logic [DATA_W-1:0] marked;
  logic [DATA_W-1:0] desc_q;
  dsc_verdict_e      verdict;

  dsc_dirty_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  dsc_dirty_decide #(
    .DATA_W  (DATA_W),
    .VLD_BIT (VLD_BIT),
    .RO_BIT  (RO_BIT),
    .MOD_BIT (MOD_BIT)
  ) u_dec (
    .desc     (mem_rdata),
    .is_write (wr_q),
    .upd_en   (en_q),
    .verdict  (verdict),
    .marked   (marked)
  );

  dsc_dirty_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .req_valid (req_valid),
    .mem_ack   (mem_ack),
    .verdict   (verdict),
    .req_ready (req_ready),
    .accept    (accept),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .desc_ld   (desc_ld),
    .res_ld    (res_ld),
    .res_grant (res_grant),
    .res_fault (res_fault)
  );

  dsc_dirty_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .upd_en    (upd_en),
    .desc_ld   (desc_ld),
    .desc_in   (marked),
    .res_ld    (res_ld),
    .res_grant (res_grant),
    .res_fault (res_fault),
    .addr_q    (mem_addr),
    .wr_q      (wr_q),
    .en_q      (en_q),
    .desc_q    (desc_q),
    .grant_q   (grant_q),
    .fault_q   (fault_q)
  );

  assign mem_wdata = desc_q;
  assign rsp_grant = grant_q;
  assign rsp_fault = fault_q;

endmodule

// File: rtl/dsc_dirty_chk.sv
module dsc_dirty_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int RO_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [1:0]        rsp_fault,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_lock,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  // R7: no write leaves the block without the lock
  a_r7_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_lock);

  // R7: the lock is not dropped before an acknowledge
  a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock && !mem_ack |=> mem_lock);

  // R2: the written descriptor has write-protect cleared
  a_r2_wdata_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[RO_BIT]);

  // R10: the response is a single-cycle pulse
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: grant and fault code agree
  a_r10_grant_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant == (rsp_fault == 2'd0)) && (rsp_fault != 2'd3));

  // R10: memory request held stable until acknowledged
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_lock));

  // R10: idle means no memory traffic; R7: first access is an unlocked read
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !mem_lock && !rsp_valid);

  a_r7_first_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req && !mem_we && !mem_lock);

endmodule

bind dsc_dirty_upd dsc_dirty_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RO_BIT (RO_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_fault (rsp_fault),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_lock  (mem_lock),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/dsc_dirty_upd_test.sv
module dsc_dirty_upd_test;

  localparam int AW = 12;
  localparam int DW = 64;
  localparam logic [63:0] VLD = 64'h1;
  localparam logic [63:0] RO  = 64'h80;
  localparam logic [63:0] MOD = 64'h0008_0000_0000_0000;
  localparam logic [63:0] PAY = 64'h00F0_0000_1234_5600;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_en = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, rsp_grant;
  logic [1:0]    rsp_fault;
  logic          mem_req, mem_we, mem_lock;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  logic [63:0] mem [16];
  bit          intf_arm = 1'b0;
  logic [63:0] intf_val = '0;
  int          wr_cnt = 0, lrd_cnt = 0, nolock_wr = 0;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dsc_dirty_upd #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with a second agent that may rewrite a word after an unlocked read
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[6:3]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        if (!mem_lock) nolock_wr <= nolock_wr + 1;
      end else begin
        mem_rdata <= mem[mem_addr[6:3]];
        if (mem_lock) lrd_cnt <= lrd_cnt + 1;
        else if (intf_arm) begin
          mem[mem_addr[6:3]] <= intf_val;
          intf_arm <= 1'b0;
        end
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 grant, 1 translation, 2 permission, 3 upgrade
  function automatic int verdict(input logic [63:0] d, input bit wr, input bit en);
    if (!d[0])             return 1;
    if (!wr || !d[7])      return 0;
    if (d[51] && en)       return 3;
    return 2;
  endfunction

  task automatic run(input string tag, input logic [3:0] idx, input bit wr, input bit en,
                     input logic [63:0] d0, input bit arm, input logic [63:0] d1, input bit hold);
    int v, lat, w0, l0;
    logic [1:0] efault;
    logic [63:0] efinal;
    bit do_wr;
    v = verdict(d0, wr, en);
    efinal = arm ? d1 : d0;
    do_wr = 1'b0;
    if (v != 3) begin
      lat = 2;
    end else begin
      v = verdict(efinal, wr, en);
      if (v != 3) lat = 4;
      else begin
        lat = 6; v = 0; do_wr = 1'b1; efinal = efinal & ~RO;
      end
    end
    efault = (v == 0) ? 2'd0 : 2'(v);
    @(negedge clk);
    mem[idx] = d0;
    intf_arm = arm;
    intf_val = d1;
    w0 = wr_cnt;
    l0 = lrd_cnt;
    req_valid = 1'b1; req_write = wr; upd_en = en; req_addr = {5'd0, idx, 3'd0};
    chk(req_ready == 1'b1, {tag, " R10 ready idle"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    for (int k = 1; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k <= lat) begin
        chk(req_ready == 1'b0, {tag, " R10 busy"}, 64'(req_ready), 64'd0);
        chk(rsp_valid == (k == lat), {tag, " R10 rsp timing"}, 64'(rsp_valid), 64'(k == lat));
      end else begin
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, {tag, " R10 back idle"},
            {62'd0, req_ready, rsp_valid}, 64'h2);
        req_valid = 1'b0;
      end
      if (k == lat) begin
        chk(rsp_grant == (efault == 2'd0) && rsp_fault == efault, {tag, " result"},
            {61'd0, rsp_grant, rsp_fault}, {61'd0, efault == 2'd0, efault});
        chk(mem[idx] == efinal, {tag, " memory"}, mem[idx], efinal);
        chk(wr_cnt - w0 == int'(do_wr), {tag, " write count"}, 64'(wr_cnt - w0), 64'(do_wr));
        chk(lrd_cnt - l0 == int'(lat > 2), {tag, " R7 locked reads"}, 64'(lrd_cnt - l0), 64'(lat > 2));
        chk(nolock_wr == 0, {tag, " R7 unlocked write"}, 64'(nolock_wr), 64'd0);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_valid && !mem_req && !mem_lock, "R1 in reset",
        {60'd0, req_ready, rsp_valid, mem_req, mem_lock}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready && !mem_req, "R1 sync release", {62'd0, req_ready, mem_req}, 64'd0);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);

    run("R5 read ro",         4'd1, 1'b0, 1'b1, PAY|VLD|RO,     1'b0, 0, 1'b0);
    run("R5 read rw mod",     4'd2, 1'b0, 1'b1, PAY|VLD|MOD,    1'b0, 0, 1'b0);
    run("R4 write rw",        4'd3, 1'b1, 1'b1, PAY|VLD,        1'b0, 0, 1'b0);
    run("R4 write rw mod",    4'd4, 1'b1, 1'b1, PAY|VLD|MOD,    1'b0, 0, 1'b1);
    run("R3 write ro nomod",  4'd5, 1'b1, 1'b1, PAY|VLD|RO,     1'b0, 0, 1'b0);
    run("R2 write ro mod",    4'd6, 1'b1, 1'b1, PAY|VLD|RO|MOD, 1'b0, 0, 1'b0);
    run("R2 dirty rewrite",   4'd6, 1'b1, 1'b1, mem[6],         1'b0, 0, 1'b0);
    run("R2 all ones",        4'd7, 1'b1, 1'b1, '1,             1'b0, 0, 1'b1);
    run("R9 enable off",      4'd8, 1'b1, 1'b0, PAY|VLD|RO|MOD, 1'b0, 0, 1'b0);
    run("R6 invalid write",   4'd9, 1'b1, 1'b1, PAY|RO|MOD,     1'b0, 0, 1'b0);
    run("R6 invalid read",    4'd10, 1'b0, 1'b1, PAY,           1'b0, 0, 1'b0);
    run("R8 became rw",       4'd11, 1'b1, 1'b1, PAY|VLD|RO|MOD, 1'b1, PAY|VLD|MOD, 1'b0);
    run("R8 mod cleared",     4'd12, 1'b1, 1'b1, PAY|VLD|RO|MOD, 1'b1, PAY|VLD|RO, 1'b0);
    run("R8 invalidated",     4'd13, 1'b1, 1'b1, PAY|VLD|RO|MOD, 1'b1, PAY|RO|MOD, 1'b0);
    run("R8 R7 fields moved", 4'd14, 1'b1, 1'b1, PAY|VLD|RO|MOD, 1'b1, 64'h7700_0000_0000_0000|VLD|RO|MOD, 1'b0);
    run("R9 R8 off armed",    4'd15, 1'b1, 1'b0, PAY|VLD|RO|MOD, 1'b1, PAY|VLD, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired R10 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule